// File: doc/BRIEF.md
# Buffered Program Command Sequencer for a NOR Flash Interface

This block is the device-side command decoder for a buffered program operation on a NOR-style flash array. It watches single-cycle bus writes (address, 16-bit data, write strobe) and walks a strict sequence. First come two unlock writes, then a setup code, then a word count n, then n+1 address/data loads into a 32-word staging buffer, then a confirm code. Any wrong step sends it to an error state. A correct confirm starts a busy period, and at the end of that period every buffered word is ANDed into a behavioural memory array. Programming can therefore only clear bits.

Bus reads are combinational from the bus address. While programming is under way, or while an error is held, reads to the bank that holds the target block return a status word. Reads to any other bank return array contents. An error stays latched until a read/reset code is written. The array comes out of reset fully erased.

States and transitions: IDLE_READ goes to GOT_FIRST on the first unlock. GOT_FIRST goes to GOT_SECOND on the second unlock, otherwise back to IDLE_READ. GOT_SECOND goes to WAIT_COUNT on the setup code, otherwise back to IDLE_READ. WAIT_COUNT goes to LOADING on a legal count, otherwise to FAULT. LOADING stays in LOADING while words remain and goes to WAIT_CONFIRM after the last word; an address outside the allowed page or block goes to FAULT. WAIT_CONFIRM goes to BUSY on the confirm code, otherwise to FAULT. BUSY goes to IDLE_READ when the busy count expires. FAULT goes to IDLE_READ on the read/reset code.

Top module: `flash_wbuf_seq`

## Requirements
- R1: After reset every array word reads 16'hFFFF, and no address returns status.
- R2: The sequence must open with data low byte 8'hAA written to address 11'h555, followed by 8'h55 written to 11'h2AA. If either write is wrong, the sequencer returns to read mode, and the writes that follow have no effect on the array or on read data.
- R3: The third write (low byte 8'h25) may go to any address; it selects the target block (address bits 10:8) and the target bank (bit 10). A count value n above 31 in the fourth write aborts the operation.
- R4: A count write whose address lies outside the target block aborts the operation.
- R5: The first load must lie in the target block. Every later load must share address bits 10:5 with the first load. Any other address aborts the operation.
- R6: Exactly n+1 loads are accepted. The next write must carry low byte 8'h29 to the target block; any other write aborts.
- R7: Each load consumes one count, even if its address repeats. A repeated address programs the last data loaded for it.
- R8: On completion each loaded word becomes old AND loaded data. Words that were not loaded keep their value.
- R9: The busy period lasts (n+1)*PROG_CYC cycles, doubled when the first load address has nonzero bits 4:0. During it, reads to the target bank return status: bit 7 is the inverse of bit 7 of the last loaded data and every other bit is 0. Reads to other banks return the array.
- R10: After completion, reads return array data. After an abort, reads to the target bank return 16'h0020 (bit 5 set) until a write with low byte 8'hF0; writes with other data leave the error held.
- R11: Writes issued during the busy period are ignored: they change neither the busy length nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W (11) | Word address for writes and reads |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data: array word or status |

## Verification
The bench uses the default build: an 11-bit word address, two banks, 256-word blocks, a 32-word buffer and two busy cycles per word. At this size the sweep can run every legal count from 0 to 31, each on a different page, with a mix of aligned and misaligned start offsets and repeated addresses. It also reprograms one page to show the AND behaviour, and walks the busy window cycle by cycle so that the exact completion edge is checked. Each abort path is driven one by one against a reference array kept in the bench.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_PROG,
        ST_ERR
    } fwb_state_e;

    localparam logic [7:0]  CODE_UNLK_A  = 8'hAA;
    localparam logic [7:0]  CODE_UNLK_B  = 8'h55;
    localparam logic [7:0]  CODE_SETUP   = 8'h25;
    localparam logic [7:0]  CODE_CONFIRM = 8'h29;
    localparam logic [7:0]  CODE_RESET   = 8'hF0;
    localparam logic [10:0] ADR_UNLK_A   = 11'h555;
    localparam logic [10:0] ADR_UNLK_B   = 11'h2AA;

endpackage

// File: rtl/fwb_cmd_fsm.sv
module fwb_cmd_fsm
    import fwb_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DW       = 16,
    parameter int BUF_N    = 32,
    parameter int BLK_LSB  = 8,
    parameter int BANKS    = 2,
    parameter int PROG_CYC = 2,
    localparam int PG_LSB  = $clog2(BUF_N),
    localparam int BANK_W  = $clog2(BANKS),
    localparam int BLK_W   = ADDR_W - BLK_LSB,
    localparam int PAGE_W  = ADDR_W - PG_LSB,
    localparam int BUSY_W  = $clog2(BUF_N * PROG_CYC * 2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output fwb_state_e        st_o,
    output logic [BANK_W-1:0] tgt_bank_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              buf_clr_o,
    output logic              buf_we_o,
    output logic [PG_LSB-1:0] buf_idx_o,
    output logic              poll_o,
    output logic              commit_o,
    output logic [BUSY_W-1:0] busy_o
);

    fwb_state_e        st, nxt;
    logic [BLK_W-1:0]  blk_q;
    logic [PAGE_W-1:0] page_q;
    logic [PG_LSB-1:0] cnt_q;
    logic [PG_LSB:0]   words_q;
    logic              first_q, misal_q, last7_q;
    logic [BUSY_W-1:0] busy_q, busy_init;

    logic [7:0] cmd;
    logic       in_blk, in_page, load_ok, over, unlk_a, unlk_b;
    logic       take_setup, take_count, take_load, take_confirm, commit;

    assign cmd       = wdata[7:0];
    assign in_blk    = (addr[ADDR_W-1:BLK_LSB] == blk_q);
    assign in_page   = (addr[ADDR_W-1:PG_LSB] == page_q);
    assign load_ok   = first_q ? in_blk : in_page;
    assign over      = (wdata > DW'(BUF_N - 1));
    assign unlk_a    = (addr[10:0] == ADR_UNLK_A);
    assign unlk_b    = (addr[10:0] == ADR_UNLK_B);
    assign busy_init = (BUSY_W'(words_q) * BUSY_W'(PROG_CYC)) << misal_q;

    // next state and step strobes
    always_comb begin
        nxt          = st;
        take_setup   = 1'b0;
        take_count   = 1'b0;
        take_load    = 1'b0;
        take_confirm = 1'b0;
        commit       = 1'b0;
        unique case (st)
            ST_READ: begin
                if (we && unlk_a && cmd == CODE_UNLK_A) nxt = ST_UNLK1;
            end
            ST_UNLK1: begin
                if (we) nxt = (unlk_b && cmd == CODE_UNLK_B) ? ST_UNLK2 : ST_READ;
            end
            ST_UNLK2: begin
                if (we) begin
                    if (cmd == CODE_SETUP) begin
                        nxt        = ST_COUNT;
                        take_setup = 1'b1;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_COUNT: begin
                if (we) begin
                    if (in_blk && !over) begin
                        nxt        = ST_LOAD;
                        take_count = 1'b1;
                    end else begin
                        nxt = ST_ERR;
                    end
                end
            end
            ST_LOAD: begin
                if (we) begin
                    if (load_ok) begin
                        take_load = 1'b1;
                        if (cnt_q == '0) nxt = ST_CONFIRM;
                    end else begin
                        nxt = ST_ERR;
                    end
                end
            end
            ST_CONFIRM: begin
                if (we) begin
                    if (in_blk && cmd == CODE_CONFIRM) begin
                        nxt          = ST_PROG;
                        take_confirm = 1'b1;
                    end else begin
                        nxt = ST_ERR;
                    end
                end
            end
            ST_PROG: begin
                if (busy_q == BUSY_W'(1)) begin
                    nxt    = ST_READ;
                    commit = 1'b1;
                end
            end
            ST_ERR: begin
                if (we && cmd == CODE_RESET) nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READ;
        else        st <= nxt;
    end

    // operation context captured along the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q   <= '0;
            page_q  <= '0;
            cnt_q   <= '0;
            words_q <= '0;
            first_q <= 1'b0;
            misal_q <= 1'b0;
            last7_q <= 1'b0;
            busy_q  <= '0;
        end else begin
            if (take_setup) begin
                blk_q   <= addr[ADDR_W-1:BLK_LSB];
                last7_q <= 1'b0;
            end
            if (take_count) begin
                cnt_q   <= wdata[PG_LSB-1:0];
                words_q <= {1'b0, wdata[PG_LSB-1:0]} + 1'b1;
                first_q <= 1'b1;
            end
            if (take_load) begin
                if (first_q) begin
                    page_q  <= addr[ADDR_W-1:PG_LSB];
                    misal_q <= (addr[PG_LSB-1:0] != '0);
                end
                first_q <= 1'b0;
                cnt_q   <= cnt_q - 1'b1;
                last7_q <= wdata[7];
            end
            if (take_confirm)                      busy_q <= busy_init;
            else if (st == ST_PROG && busy_q != '0) busy_q <= busy_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        st_o       = st;
        tgt_bank_o = blk_q[BLK_W-1 -: BANK_W];
        page_o     = page_q;
        buf_clr_o  = take_count;
        buf_we_o   = take_load;
        buf_idx_o  = addr[PG_LSB-1:0];
        poll_o     = ~last7_q;
        commit_o   = commit;
        busy_o     = busy_q;
    end

endmodule

// File: rtl/fwb_wbuf.sv
module fwb_wbuf #(
    parameter int DW     = 16,
    parameter int BUF_N  = 32,
    localparam int IDX_W = $clog2(BUF_N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DW-1:0]              wd,
    output logic [BUF_N-1:0][DW-1:0]   dat_o,
    output logic [BUF_N-1:0]           vld_o
);

    for (genvar g = 0; g < BUF_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dat_o[g] <= '0;
                vld_o[g] <= 1'b0;
            end else if (clr) begin
                vld_o[g] <= 1'b0;
            end else if (we && idx == IDX_W'(g)) begin
                dat_o[g] <= wd;
                vld_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fwb_array.sv
module fwb_array #(
    parameter int ADDR_W  = 11,
    parameter int DW      = 16,
    parameter int BUF_N   = 32,
    localparam int PG_LSB = $clog2(BUF_N),
    localparam int PAGE_W = ADDR_W - PG_LSB,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [PAGE_W-1:0]        page,
    input  logic [BUF_N-1:0][DW-1:0] dat,
    input  logic [BUF_N-1:0]         vld,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DW-1:0]            rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < BUF_N; i++) begin
                if (vld[i]) mem[{page, PG_LSB'(i)}] <= mem[{page, PG_LSB'(i)}] & dat[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_wbuf_seq.sv
module flash_wbuf_seq
    import fwb_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DW       = 16,
    parameter int BUF_N    = 32,
    parameter int BLK_LSB  = 8,
    parameter int BANKS    = 2,
    parameter int PROG_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);

    localparam int PG_LSB = $clog2(BUF_N);
    localparam int BANK_W = $clog2(BANKS);
    localparam int PAGE_W = ADDR_W - PG_LSB;
    localparam int BUSY_W = $clog2(BUF_N * PROG_CYC * 2 + 1);

    fwb_state_e              st;
    logic [BANK_W-1:0]       tgt_bank;
    logic [PAGE_W-1:0]       page;
    logic                    buf_clr, buf_we, poll, commit;
    logic [PG_LSB-1:0]       buf_idx;
    logic [BUSY_W-1:0]       busy_cnt;
    logic [BUF_N-1:0][DW-1:0] buf_dat;
    logic [BUF_N-1:0]        buf_vld;
    logic [DW-1:0]           arr_rd, status;
    logic                    show_status;

    fwb_cmd_fsm #(
        .ADDR_W(ADDR_W), .DW(DW), .BUF_N(BUF_N), .BLK_LSB(BLK_LSB),
        .BANKS(BANKS), .PROG_CYC(PROG_CYC)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .st_o(st), .tgt_bank_o(tgt_bank), .page_o(page), .buf_clr_o(buf_clr),
        .buf_we_o(buf_we), .buf_idx_o(buf_idx), .poll_o(poll), .commit_o(commit),
        .busy_o(busy_cnt)
    );

    fwb_wbuf #(.DW(DW), .BUF_N(BUF_N)) i_wbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .idx(buf_idx),
        .wd(bus_wdata), .dat_o(buf_dat), .vld_o(buf_vld)
    );

    fwb_array #(.ADDR_W(ADDR_W), .DW(DW), .BUF_N(BUF_N)) i_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(page), .dat(buf_dat),
        .vld(buf_vld), .rd_addr(bus_addr), .rd_data(arr_rd)
    );

    always_comb begin
        status    = '0;
        status[7] = (st == ST_PROG) & poll;
        status[5] = (st == ST_ERR);
    end

    assign show_status = (st == ST_PROG || st == ST_ERR) &&
                         (bus_addr[ADDR_W-1 -: BANK_W] == tgt_bank);
    assign bus_rdata   = show_status ? status : arr_rd;

endmodule

// File: rtl/fwb_chk.sv
module fwb_chk
    import fwb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DW     = 16,
    parameter int BUF_N  = 32,
    parameter int BANK_W = 1,
    parameter int BUSY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input fwb_state_e        st,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [BANK_W-1:0] tgt_bank,
    input logic [BUSY_W-1:0] busy_cnt
);

    AST_OVER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && bus_we && bus_wdata > DW'(BUF_N - 1)) |=> st == ST_ERR); // R3

    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONFIRM && bus_we && bus_wdata[7:0] != CODE_CONFIRM) |=> st == ST_ERR); // R6

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && busy_cnt > BUSY_W'(1)) |=>
        (st == ST_PROG && busy_cnt == $past(busy_cnt) - BUSY_W'(1))); // R11

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && !(bus_we && bus_wdata[7:0] == CODE_RESET)) |=> st == ST_ERR); // R10

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && bus_we && bus_wdata[7:0] == CODE_RESET) |=> st == ST_READ); // R10

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && bus_addr[ADDR_W-1 -: BANK_W] == tgt_bank) |->
        (bus_rdata[5] == 1'b0 && bus_rdata[DW-1:8] == '0)); // R9

endmodule

bind flash_wbuf_seq fwb_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .BUF_N(BUF_N), .BANK_W(BANK_W), .BUSY_W(BUSY_W)
) i_fwb_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_bank(tgt_bank),
    .busy_cnt(busy_cnt)
);

// File: tb/test_flash_wbuf_seq.sv
`timescale 1ns/1ps
module test_flash_wbuf_seq;

    localparam int PC = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we;
    logic [10:0] addr;
    logic [15:0] wdata, rdata;
    logic [15:0] ref_m [2048];
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flash_wbuf_seq i_flash_wbuf_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata)
    );

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = 11'(a); wdata = 16'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk(input int a, input logic [15:0] exp, input string tag);
        addr = 11'(a);
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: addr %h got %h expected %h", tag, 11'(a), rdata, exp);
        end
    endtask

    task automatic unlock_setup(input int a);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(a, 16'h0025);
    endtask

    task automatic do_prog(input int n, input int pg, input int st_off,
                           input bit dup, input bit poke, input string tag);
        int base, ob, nb, off;
        logic [15:0] bd [32];
        bit          bv [32];
        logic [15:0] d, dl;
        base = pg * 32;
        ob   = (base ^ 1024) + 1;
        dl   = '0;
        for (int i = 0; i < 32; i++) begin bv[i] = 1'b0; bd[i] = '0; end
        unlock_setup(base + 7);
        wr(base + 9, n);
        for (int k = 0; k <= n; k++) begin
            off = (st_off + k * 5) % 32;
            if (dup && k == n && n > 0) off = st_off;
            d = 16'(n * 16'h1357 + k * 16'h0F1D) ^ 16'hA5A5;
            wr(base + off, d);
            bd[off] = d; bv[off] = 1'b1; dl = d;
        end
        wr(base + 3, 16'h0029);
        nb = (n + 1) * PC * ((st_off != 0) ? 2 : 1);
        if (poke) begin
            wr(base, 16'h00F0);          // R11: ignored while busy
            repeat (nb - 3) @(negedge clk);
        end else begin
            repeat (nb - 1) @(negedge clk);
        end
        chk(base, dl[7] ? 16'h0000 : 16'h0080, "R9 busy status last cycle");
        chk(ob, ref_m[ob], "R9 other bank during busy");
        @(negedge clk);
        for (int i = 0; i < 32; i++) if (bv[i]) ref_m[base + i] = ref_m[base + i] & bd[i];
        chk(base + st_off, ref_m[base + st_off], "R10 back to read mode");
        for (int i = 0; i < 32; i++) chk(base + i, ref_m[base + i], tag);
    endtask

    task automatic err_release(input int x, input string tag);
        chk(x, 16'h0020, tag);
        chk(x ^ 1024, ref_m[x ^ 1024], "R10 other bank during error");
        wr(x, 16'h1234);
        chk(x, 16'h0020, "R10 error held after other data");
        wr(x, 16'h00F0);
        chk(x, ref_m[x], "R10 read/reset clears error");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int x;
        for (int i = 0; i < 2048; i++) ref_m[i] = 16'hFFFF;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased after reset, both banks
        for (int i = 0; i < 64; i++) chk(i * 32 + (i % 32), 16'hFFFF, "R1 reset array");

        x = 1280;   // page 40, block 5, bank 1
        // R2: wrong second unlock data, then a would-be sequence
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0054);
        wr(x, 16'h0025); wr(x, 16'h0000); wr(x, 16'h0000); wr(x, 16'h0029);
        repeat (4) @(negedge clk);
        chk(x, ref_m[x], "R2 bad unlock data no effect");
        // R2: wrong first unlock address
        wr(11'h554, 16'h00AA); wr(11'h2AA, 16'h0055);
        wr(x, 16'h0025); wr(x, 16'h0000); wr(x, 16'h0000); wr(x, 16'h0029);
        repeat (4) @(negedge clk);
        chk(x, ref_m[x], "R2 bad unlock address no effect");

        // R3: count 32 exceeds buffer
        unlock_setup(x + 5); wr(x, 32);
        err_release(x, "R3 oversize count aborts");
        // R4: count to another block
        unlock_setup(x + 5); wr(x + 256, 0);
        err_release(x, "R4 count outside block aborts");
        // R5: second load outside page
        unlock_setup(x + 5); wr(x, 3); wr(x + 1, 16'h0000); wr(x + 40, 16'h0000);
        err_release(x, "R5 load outside page aborts");
        chk(x + 1, ref_m[x + 1], "R5 aborted load not programmed");
        // R5: first load outside block
        unlock_setup(x + 5); wr(x, 0); wr(x + 256, 16'h0000);
        err_release(x, "R5 first load outside block aborts");
        // R6: wrong confirm code
        unlock_setup(x + 5); wr(x, 1); wr(x, 16'h0000); wr(x + 1, 16'h0000);
        wr(x + 2, 16'h0030);
        err_release(x, "R6 wrong confirm aborts");
        // R6: one load too many
        unlock_setup(x + 5); wr(x, 1); wr(x, 16'h0000); wr(x + 1, 16'h0000);
        wr(x + 2, 16'h0000);
        err_release(x, "R6 extra load aborts");
        chk(x, ref_m[x], "R6 aborted data not programmed");
        chk(x + 1, ref_m[x + 1], "R6 aborted data not programmed");

        // sweep of every count, aligned and misaligned, with duplicates (R7, R8, R9)
        for (int n = 0; n < 32; n++) begin
            int so;
            so = (n % 3 == 1) ? (n * 3) % 32 : 0;
            if (n == 6)
                do_prog(n, (n * 11 + 5) % 64, so, 1'b0, 1'b1, "R11 busy write ignored");
            else if (n % 4 == 2)
                do_prog(n, (n * 11 + 5) % 64, so, 1'b1, 1'b0, "R7 repeated address");
            else
                do_prog(n, (n * 11 + 5) % 64, so, 1'b0, 1'b0, "R8 program result");
        end
        // R8: reprogram pages to show bits only clear
        do_prog(31, 5, 0, 1'b0, 1'b0, "R8 reprogram ANDs");
        do_prog(17, 16, 9, 1'b1, 1'b0, "R8 reprogram misaligned");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule